// File: doc/BRIEF.md
# Data Access Translation Fault Checker

This block turns a load or store virtual address into a physical address and decides whether the access may go ahead. It sits around the result of a translation-buffer lookup. The block takes the address, the access size, the direction, a physical-mode flag, the current privilege mode, a flag that marks page-table references, and the lookup result. The lookup result holds a hit flag, a physical page number, per-mode read and write enable masks, and the trap-on-read and trap-on-write bits. The block returns the physical address, a success flag, a fault code and a status word. The status word records why the access failed.

The checks run in a fixed priority order:

1. Alignment.
2. Physical-mode bypass.
3. Bad virtual address.
4. Kernel-only direct-mapped superpage region.
5. Translation miss.
6. Per-mode permission and trap-on-access bits.

All results come out of registers one clock after the request. The lookup array and any cacheability handling live outside this block.

Top module: `data_xlate_check`

## Requirements
- R1: Access size code `sz` selects 1, 2, 4 or 8 bytes for codes 0, 1, 2 and 3. If the address is not a multiple of the size, the fault is ALIGN (code 1). This check wins over every other check, including physical mode. In the status word only bit 0 (write) may be set, and only for a store.
- R2: An aligned access with `phys_mode` set succeeds. The physical address equals the virtual address, the status is zero, and no other check applies.
- R3: A virtual address is bad when its bits 63:47 are neither all zeros nor all ones. A bad address gives fault PAGE (code 2). The status holds bad-VA (bit 5), access violation (bit 1), and write (bit 0) for a store.
- R4: An address with bits 47:41 equal to 0x7E lies in the superpage region. An access there in any mode other than kernel (mode code 0) gives fault ACV (code 3), with status bit 1 and, for a store, bit 0.
- R5: A kernel access to the superpage region succeeds with a direct mapping. The physical address is made of the virtual address bits 43:0, with bits 43:40 all copied from bit 40 and bits 63:44 set to zero.
- R6: A translation miss gives fault MISS_PTE (code 5) when `pte_ref` is set, and MISS (code 4) otherwise. The status holds the miss bit (bit 4) and, for a store, bit 0.
- R7: On a permitted hit, the physical address is the page number shifted left by 13, plus the virtual address bits 12:0.
- R8: A store whose write-enable bit, indexed by the mode code, is clear gives fault PAGE with status bits 0 and 1, plus bit 3 if trap-on-write is set. A permitted store with trap-on-write set gives fault PAGE with status bits 0 and 3.
- R9: A load whose read-enable bit, indexed by the mode code, is clear gives fault ACV with status bit 1, plus bit 2 if trap-on-read is set. A permitted load with trap-on-read set gives fault PAGE with status bit 2 only.
- R10: The outputs appear one cycle after the request. `rsp_valid` follows `req_valid` one cycle later.
- R11: `rsp_hit` is set exactly when the fault is NONE (code 0). A success carries a zero status word, and any fault carries a physical address of zero.
- R12: Reset clears `rsp_valid`, `rsp_hit`, `rsp_fault`, `rsp_status` and `rsp_pa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| va | input | 64 | Virtual address |
| sz | input | 2 | Access size code (bytes = 1 << sz) |
| is_write | input | 1 | Store when set, load when clear |
| phys_mode | input | 1 | Bypass translation |
| priv_mode | input | 2 | Privilege mode, 0 is kernel |
| pte_ref | input | 1 | Access is a page-table reference |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_ppn | input | 31 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_trap_rd | input | 1 | Trap on any read of the page |
| tlb_trap_wr | input | 1 | Trap on any write of the page |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 64 | Physical address, zero on a fault |
| rsp_hit | output | 1 | Access allowed |
| rsp_fault | output | 3 | Fault code |
| rsp_status | output | 6 | Status word |

## Verification
Every result (address, success flag, fault code, status, valid) is due exactly one rising edge after the request is driven. There are no other pipeline stages. The bench drives each request on a falling edge, lets one rising edge pass, and samples all outputs on the next falling edge. Each request therefore has a single, unambiguous result cycle. An idle cycle is checked the same way, to confirm that valid drops one edge after the request goes away.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ALIGN    = 3'd1,
    FLT_PAGE     = 3'd2,
    FLT_ACV      = 3'd3,
    FLT_MISS     = 3'd4,
    FLT_MISS_PTE = 3'd5
  } fault_e;

  localparam int ST_W     = 6;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_TRAPR = 2;
  localparam int ST_TRAPW = 3;
  localparam int ST_MISS  = 4;
  localparam int ST_BADVA = 5;

  localparam int SP_LO   = 41;
  localparam int SP_TAG  = 'h7E;
  localparam int EXT_BIT = 40;

  localparam logic [1:0] MODE_KERNEL = 2'd0;

endpackage

// File: rtl/xlate_align_chk.sv
module xlate_align_chk #(
  parameter int VA_W = 64,
  parameter int SZ_W = 2
) (
  input  logic [VA_W-1:0] va,
  input  logic [SZ_W-1:0] sz,
  output logic            misaligned
);
  localparam int N_SZ = 1 << SZ_W;

  logic [N_SZ-1:0] bad_by_sz;

  // one low-bit test per size code
  for (genvar g = 0; g < N_SZ; g++) begin : g_sz
    if (g == 0) begin : g_byte
      assign bad_by_sz[g] = 1'b0;
    end else begin : g_wide
      assign bad_by_sz[g] = |va[g-1:0];
    end
  end

  assign misaligned = bad_by_sz[sz];

endmodule

// File: rtl/xlate_region_dec.sv
module xlate_region_dec #(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 48,
  parameter int PA_IMPL = 44,
  parameter int SP_LO   = 41,
  parameter int SP_TAG  = 'h7E,
  parameter int EXT_BIT = 40
) (
  input  logic [VA_W-1:0] va,
  output logic            va_bad,
  output logic            in_superpage,
  output logic [VA_W-1:0] sp_pa
);
  localparam int SP_W  = VA_IMPL - SP_LO;
  localparam int TOP_W = VA_W - VA_IMPL + 1;

  logic [TOP_W-1:0] top_bits;
  logic [PA_IMPL-1:0] sp_core;

  assign top_bits     = va[VA_W-1:VA_IMPL-1];
  assign va_bad       = !((&top_bits) || !(|top_bits));
  assign in_superpage = (va[VA_IMPL-1:SP_LO] == SP_W'(SP_TAG));

  // bits at and above the extension bit copy it, the rest pass through
  for (genvar b = 0; b < PA_IMPL; b++) begin : g_pa
    if (b < EXT_BIT) begin : g_low
      assign sp_core[b] = va[b];
    end else begin : g_ext
      assign sp_core[b] = va[EXT_BIT];
    end
  end

  assign sp_pa = VA_W'(sp_core);

endmodule

// File: rtl/xlate_perm_chk.sv
module xlate_perm_chk
  import xlate_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic [MODE_W-1:0]       mode,
  input  logic                    is_write,
  input  logic [(1<<MODE_W)-1:0]  rd_en,
  input  logic [(1<<MODE_W)-1:0]  wr_en,
  input  logic                    trap_rd,
  input  logic                    trap_wr,
  output logic                    denied,
  output fault_e                  fault,
  output logic [ST_W-1:0]         status
);
  logic allowed;
  logic trap;

  assign allowed = is_write ? wr_en[mode] : rd_en[mode];
  assign trap    = is_write ? trap_wr : trap_rd;
  assign denied  = !allowed || trap;

  always_comb begin
    status = '0;
    fault  = FLT_NONE;
    if (denied) begin
      status[ST_WR]    = is_write;
      status[ST_ACV]   = !allowed;
      status[ST_TRAPR] = !is_write && trap;
      status[ST_TRAPW] = is_write && trap;
      fault            = (!allowed && !is_write) ? FLT_ACV : FLT_PAGE;
    end
  end

endmodule

// File: rtl/data_xlate_check.sv
module data_xlate_check
  import xlate_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL   = 48,
  parameter int PA_IMPL   = 44,
  parameter int PAGE_BITS = 13,
  parameter int MODE_W    = 2,
  parameter int SZ_W      = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic [VA_W-1:0]              va,
  input  logic [SZ_W-1:0]              sz,
  input  logic                         is_write,
  input  logic                         phys_mode,
  input  logic [MODE_W-1:0]            priv_mode,
  input  logic                         pte_ref,
  input  logic                         tlb_hit,
  input  logic [PA_IMPL-PAGE_BITS-1:0] tlb_ppn,
  input  logic [(1<<MODE_W)-1:0]       tlb_rd_en,
  input  logic [(1<<MODE_W)-1:0]       tlb_wr_en,
  input  logic                         tlb_trap_rd,
  input  logic                         tlb_trap_wr,
  output logic                         rsp_valid,
  output logic [VA_W-1:0]              rsp_pa,
  output logic                         rsp_hit,
  output logic [2:0]                   rsp_fault,
  output logic [ST_W-1:0]              rsp_status
);
  localparam int PPN_W = PA_IMPL - PAGE_BITS;

  logic            misaligned;
  logic            va_bad;
  logic            in_sp;
  logic [VA_W-1:0] sp_pa;
  logic            perm_denied;
  fault_e          perm_fault;
  logic [ST_W-1:0] perm_status;

  fault_e          nx_fault;
  logic [ST_W-1:0] nx_status;
  logic [VA_W-1:0] nx_pa;

  xlate_align_chk #(.VA_W(VA_W), .SZ_W(SZ_W)) u_align (
    .va(va), .sz(sz), .misaligned(misaligned)
  );

  xlate_region_dec #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_IMPL(PA_IMPL),
    .SP_LO(SP_LO), .SP_TAG(SP_TAG), .EXT_BIT(EXT_BIT)
  ) u_region (
    .va(va), .va_bad(va_bad), .in_superpage(in_sp), .sp_pa(sp_pa)
  );

  xlate_perm_chk #(.MODE_W(MODE_W)) u_perm (
    .mode(priv_mode), .is_write(is_write),
    .rd_en(tlb_rd_en), .wr_en(tlb_wr_en),
    .trap_rd(tlb_trap_rd), .trap_wr(tlb_trap_wr),
    .denied(perm_denied), .fault(perm_fault), .status(perm_status)
  );

  // fixed-priority resolution of all checks
  always_comb begin
    nx_fault  = FLT_NONE;
    nx_status = '0;
    nx_pa     = '0;
    if (misaligned) begin
      nx_fault         = FLT_ALIGN;
      nx_status[ST_WR] = is_write;
    end else if (phys_mode) begin
      nx_pa = va;
    end else if (va_bad) begin
      nx_fault            = FLT_PAGE;
      nx_status[ST_WR]    = is_write;
      nx_status[ST_ACV]   = 1'b1;
      nx_status[ST_BADVA] = 1'b1;
    end else if (in_sp) begin
      if (priv_mode != MODE_W'(MODE_KERNEL)) begin
        nx_fault          = FLT_ACV;
        nx_status[ST_WR]  = is_write;
        nx_status[ST_ACV] = 1'b1;
      end else begin
        nx_pa = sp_pa;
      end
    end else if (!tlb_hit) begin
      nx_fault           = pte_ref ? FLT_MISS_PTE : FLT_MISS;
      nx_status[ST_WR]   = is_write;
      nx_status[ST_MISS] = 1'b1;
    end else if (perm_denied) begin
      nx_fault  = perm_fault;
      nx_status = perm_status;
    end else begin
      nx_pa = VA_W'({tlb_ppn, va[PAGE_BITS-1:0]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_pa     <= '0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= FLT_NONE;
      rsp_status <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_pa     <= nx_pa;
        rsp_hit    <= (nx_fault == FLT_NONE);
        rsp_fault  <= nx_fault;
        rsp_status <= nx_status;
      end
    end
  end

  // R10
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R11
  hit_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_fault == FLT_NONE && rsp_status == '0));
  // R11
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0));
  // R1
  align_status_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == FLT_ALIGN) |-> ((rsp_status & ~ST_W'(1 << ST_WR)) == '0));
  // R2
  phys_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && phys_mode && !misaligned) |=> (rsp_hit && rsp_pa == $past(va)));
  // R6
  miss_status_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_fault == FLT_MISS || rsp_fault == FLT_MISS_PTE)) |-> rsp_status[ST_MISS]);
  // R5
  sp_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !phys_mode && !misaligned && !va_bad && in_sp &&
     priv_mode == MODE_W'(MODE_KERNEL))
    |=> (rsp_hit && rsp_pa[VA_W-1:PA_IMPL] == '0 &&
         ($countones(rsp_pa[PA_IMPL-1:EXT_BIT]) == 0 ||
          $countones(rsp_pa[PA_IMPL-1:EXT_BIT]) == PA_IMPL - EXT_BIT)));
  // R12
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !rsp_hit && rsp_status == '0 && rsp_pa == '0));

endmodule

// File: tb/sim_data_xlate_check.sv
module sim_data_xlate_check;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] va = '0;
  logic [1:0]  sz = '0;
  logic        is_write = 1'b0;
  logic        phys_mode = 1'b0;
  logic [1:0]  priv_mode = '0;
  logic        pte_ref = 1'b0;
  logic        tlb_hit = 1'b0;
  logic [30:0] tlb_ppn = '0;
  logic [3:0]  tlb_rd_en = '0;
  logic [3:0]  tlb_wr_en = '0;
  logic        tlb_trap_rd = 1'b0;
  logic        tlb_trap_wr = 1'b0;
  logic        rsp_valid;
  logic [63:0] rsp_pa;
  logic        rsp_hit;
  logic [2:0]  rsp_fault;
  logic [5:0]  rsp_status;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_P/2) clk = ~clk;

  data_xlate_check u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .va(va), .sz(sz),
    .is_write(is_write), .phys_mode(phys_mode), .priv_mode(priv_mode),
    .pte_ref(pte_ref), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
    .tlb_trap_rd(tlb_trap_rd), .tlb_trap_wr(tlb_trap_wr),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_status(rsp_status)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent model of the requirements
  task automatic model(output logic [63:0] pa, output logic h,
                       output logic [2:0] f, output logic [5:0] st, output string tag);
    logic [16:0] top;
    logic        en;
    logic        tr;
    pa = '0; f = 3'd0; st = '0; tag = "R7";
    top = va[63:47];
    if ((va & ((64'd1 << sz) - 64'd1)) != 0) begin
      f = 3'd1; st = {5'b0, is_write}; tag = "R1";
    end else if (phys_mode) begin
      pa = va; tag = "R2";
    end else if (top != 17'h0 && top != 17'h1FFFF) begin
      f = 3'd2; st = {1'b1, 3'b0, 1'b1, is_write}; tag = "R3";
    end else if (va[47:41] == 7'h7E) begin
      if (priv_mode != 2'd0) begin
        f = 3'd3; st = {4'b0, 1'b1, is_write}; tag = "R4";
      end else begin
        tag = "R5";
        if (va[40]) pa = {20'h0, 4'hF, va[39:0]};
        else        pa = {24'h0, va[39:0]};
      end
    end else if (!tlb_hit) begin
      f = pte_ref ? 3'd5 : 3'd4; st = {1'b0, 1'b1, 3'b0, is_write}; tag = "R6";
    end else begin
      en = is_write ? tlb_wr_en[priv_mode] : tlb_rd_en[priv_mode];
      tr = is_write ? tlb_trap_wr : tlb_trap_rd;
      if (is_write && (!en || tr)) begin
        f = 3'd2; st = {2'b0, tr, 1'b0, !en, 1'b1}; tag = "R8";
      end else if (!is_write && !en) begin
        f = 3'd3; st = {3'b0, tr, 2'b10}; tag = "R9";
      end else if (!is_write && tr) begin
        f = 3'd2; st = 6'b000100; tag = "R9";
      end else begin
        pa = {20'h0, tlb_ppn, va[12:0]};
      end
    end
    h = (f == 3'd0);
  endtask

  task automatic apply(input logic [63:0] a, input logic [1:0] s, input logic w,
                       input logic ph, input logic [1:0] m, input logic pr,
                       input logic th, input logic [30:0] pn, input logic [3:0] re,
                       input logic [3:0] we, input logic trd, input logic twr);
    logic [63:0] e_pa;
    logic        e_h;
    logic [2:0]  e_f;
    logic [5:0]  e_st;
    string       tag;
    @(negedge clk);
    req_valid = 1'b1; va = a; sz = s; is_write = w; phys_mode = ph;
    priv_mode = m; pte_ref = pr; tlb_hit = th; tlb_ppn = pn;
    tlb_rd_en = re; tlb_wr_en = we; tlb_trap_rd = trd; tlb_trap_wr = twr;
    model(e_pa, e_h, e_f, e_st, tag);
    @(negedge clk);
    check({tag, " R10 valid"}, 128'(rsp_valid), 128'(1'b1));
    check({tag, " fault"}, 128'(rsp_fault), 128'(e_f));
    check({tag, " status"}, 128'(rsp_status), 128'(e_st));
    check({tag, " R11 hit"}, 128'(rsp_hit), 128'(e_h));
    check({tag, " pa"}, 128'(rsp_pa), 128'(e_pa));
  endtask

  initial begin
    #(CLK_P * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check("R12 valid", 128'(rsp_valid), 128'(1'b0));
    check("R12 hit", 128'(rsp_hit), 128'(1'b0));
    check("R12 fault", 128'(rsp_fault), 128'(3'd0));
    check("R12 status", 128'(rsp_status), 128'(6'd0));
    check("R12 pa", 128'(rsp_pa), 128'(64'd0));

    // directed corner cases
    apply(64'h3, 2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 31'h5, 4'hF, 4'hF, 1'b0, 1'b0); // R1 wins over phys
    apply(64'hDEAD_BEEF_0000_1238, 2'd3, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0); // R2
    apply(64'h0001_0000_0000_0000, 2'd2, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 31'h1, 4'hF, 4'hF, 1'b0, 1'b0); // R3
    apply(64'hFFFF_FC00_0000_1000, 2'd3, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1, 31'h1, 4'hF, 4'hF, 1'b0, 1'b0); // R4
    apply(64'hFFFF_FD23_4567_8000, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0); // R5 bit40 set
    apply(64'hFFFF_FC23_4567_8004, 2'd2, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0); // R5 bit40 clear
    apply(64'h0000_1234_5678_0000, 2'd0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 31'h0, 4'hF, 4'hF, 1'b0, 1'b0); // R6 pte
    apply(64'h0000_1234_5678_0000, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 31'h0, 4'hF, 4'hF, 1'b0, 1'b0); // R6 native
    apply(64'h0000_1234_5678_1FFF, 2'd0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 31'h7FFF_FFFF, 4'h4, 4'h0, 1'b0, 1'b0); // R7
    apply(64'h0000_0000_0000_2000, 2'd3, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 31'h3, 4'hF, 4'hD, 1'b0, 1'b1); // R8 deny+trap
    apply(64'h0000_0000_0000_2000, 2'd3, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 31'h3, 4'hF, 4'h2, 1'b0, 1'b1); // R8 trap only
    apply(64'h0000_0000_0000_2000, 2'd3, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 31'h3, 4'h7, 4'hF, 1'b1, 1'b0); // R9 deny+trap
    apply(64'h0000_0000_0000_2000, 2'd3, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 31'h3, 4'h8, 4'hF, 1'b1, 1'b0); // R9 trap only

    // R10 idle cycle drops valid
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 idle valid", 128'(rsp_valid), 128'(1'b0));

    // constrained random mix
    for (int i = 0; i < 800; i++) begin
      logic [63:0] a;
      logic [1:0]  s;
      int          kind;
      kind = int'($urandom_range(0, 4));
      s = 2'($urandom_range(0, 3));
      a = {$urandom, $urandom};
      case (kind)
        0: a[63:47] = '0;
        1: a[63:47] = '1;
        2: begin a[63:48] = '1; a[47:41] = 7'h7E; end
        default: ;
      endcase
      if ($urandom_range(0, 3) != 0) a = a & ~((64'd1 << s) - 64'd1);
      apply(a, s, 1'($urandom), ($urandom_range(0, 9) == 0), 2'($urandom),
            1'($urandom), ($urandom_range(0, 4) != 0), 31'($urandom),
            4'($urandom), 4'($urandom), ($urandom_range(0, 3) == 0),
            ($urandom_range(0, 3) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule